// File: doc/BRIEF.md
# Standalone Per-Channel Bit-Error Test Controller

This block sits behind six receive channels. It runs a continuous bit-error test on one channel or on all of them, with no test access port involved. A single activate input starts and stops the run. Before the controller acts on that input, the input must hold a new level for a minimum number of clocks. A 3-bit select chooses which channels are tested. A mode input chooses between a sticky gross-error report and a per-bit error report. Both are latched when the run starts.

On a channel under test, the block checks the received 10-bit words against a pseudo-random pattern. The first word of the run sets the starting point of that pattern. The channel's data pins then carry the error report instead of the received data, and its lock output is held low. Channels that are not under test pass their received words and lock signals straight through in the same cycle. This makes it possible to measure how live traffic on nearby channels affects the error rate of one channel.

Top module: `bert_standalone_ctrl`

## Requirements
- R1: The filtered activate state changes only after the raw activate input has held the opposite level for 4 consecutive clock samples. A shorter excursion has no effect. The run continues until the input has been low for 4 samples.
- R2: After reset the block is inactive, and every channel passes its data and lock inputs unchanged.
- R3: Select value 0 tests all six channels. A value n from 1 to 6 tests only channel n, whose word occupies data bits [(n-1)*10 +: 10]. Value 7 tests no channel.
- R4: While a channel is under test, its lock output is 0.
- R5: With the mode input at 0 (gross mode), from the first word on a tested channel that has any mismatching bit, all 10 of that channel's data outputs are 1. They stay 1 until the run ends. A new run starts with them cleared.
- R6: With the mode input at 1 (bit mode), data output bit i of a tested channel is 1 exactly in the cycle in which received bit i mismatches the expected bit, with no latching.
- R7: An untested channel's data and lock outputs equal its inputs in the same cycle.
- R8: The first word received in a run sets the reference and is not checked, so the outputs of a tested channel are 0 in that cycle. Each following expected word is {prev[8:0], prev[9] ^ prev[6]}, where prev is the previous expected word.
- R9: The select and mode inputs are sampled in the clock in which the filtered activate state rises. Changes to them during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_i | input | 1 | Raw test activate request |
| mode_req_i | input | 1 | Report mode: 0 gross, 1 per bit |
| chan_sel_i | input | 3 | Channel select (0 all, 1-6 one channel, 7 none) |
| rx_data_i | input | 60 | Received words, channel c at bits [c*10 +: 10] |
| rx_lock_i | input | 6 | Per-channel lock from the receivers |
| data_o | output | 60 | Passed-through words or error reports |
| lock_o | output | 6 | Passed-through lock, low on tested channels |

## Verification
The hardest case to reach is a sticky gross report that has to survive the filter's deactivation delay, because this involves three things at once. The report must stay set through the four clocks in which the activate input is already low, it must not appear on any other channel, and it must be gone when a later run starts. The stimulus runs an all-channel gross test, injects single-bit faults on two channels in separate cycles, and sends clean words afterwards. It then drops the activate input, checks every cycle of the delay, and starts a new run. Configuration changes in the middle of a run, and activate pulses that are one clock too short, are covered in the same way.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int NUM_LANES = 6;
  localparam int WORD_W    = 10;
  localparam int SEL_W     = 3;
  localparam int FILT_LEN  = 4;
  localparam int TAP_HI    = 9;
  localparam int TAP_LO    = 6;
  localparam int BUS_W     = NUM_LANES * WORD_W;

  function automatic logic [WORD_W-1:0] pat_next(input logic [WORD_W-1:0] w);
    return {w[WORD_W-2:0], w[TAP_HI] ^ w[TAP_LO]};
  endfunction
endpackage

// File: rtl/bert_act_filter.sv
module bert_act_filter #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic          level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    rise_o  = 1'b0;
    if (raw_i != level_q) begin
      if (cnt_q == CW'(HOLD - 1)) begin
        level_d = raw_i;
        rise_o  = raw_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = level_q;

  // Checker: independent run length of disagreeing samples, saturating.
  logic [CW-1:0] mis_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_run <= '0;
    end else if (raw_i != level_q) begin
      if (mis_run != CW'(HOLD)) mis_run <= mis_run + 1'b1;
    end else begin
      mis_run <= '0;
    end
  end

  a_r1_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(mis_run) >= CW'(HOLD - 1)));
endmodule

// File: rtl/bert_lane.sv
module bert_lane
  import bert_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_i,
  input  logic              bitmode_i,
  input  logic [WORD_W-1:0] rx_i,
  input  logic              lock_i,
  output logic [WORD_W-1:0] data_o,
  output logic              lock_o
);
  logic [WORD_W-1:0] ref_q, ref_d;
  logic              seeded_q, seeded_d;
  logic              gross_q, gross_d;
  logic [WORD_W-1:0] err;
  logic              any_err;
  logic [WORD_W-1:0] report;

  assign err     = seeded_q ? (rx_i ^ ref_q) : '0;
  assign any_err = |err;

  always_comb begin
    ref_d    = ref_q;
    seeded_d = seeded_q;
    gross_d  = gross_q;
    if (!test_i) begin
      seeded_d = 1'b0;
      gross_d  = 1'b0;
    end else if (!seeded_q) begin
      ref_d    = pat_next(rx_i);
      seeded_d = 1'b1;
    end else begin
      ref_d   = pat_next(ref_q);
      gross_d = gross_q | any_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      seeded_q <= 1'b0;
      gross_q  <= 1'b0;
    end else begin
      ref_q    <= ref_d;
      seeded_q <= seeded_d;
      gross_q  <= gross_d;
    end
  end

  assign report = bitmode_i ? err : {WORD_W{gross_q | any_err}};
  assign data_o = test_i ? report : rx_i;
  assign lock_o = test_i ? 1'b0 : lock_i;

  a_r8_seed_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_i) |-> (data_o == '0));

  a_r5_gross_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (test_i && !bitmode_i && (&data_o)) |=> (!test_i || (&data_o)));

  a_r4_lock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (test_i && $past(test_i)) |-> (lock_o == 1'b0));
endmodule

// File: rtl/bert_standalone_ctrl.sv
module bert_standalone_ctrl
  import bert_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_i,
  input  logic                 mode_req_i,
  input  logic [SEL_W-1:0]     chan_sel_i,
  input  logic [BUS_W-1:0]     rx_data_i,
  input  logic [NUM_LANES-1:0] rx_lock_i,
  output logic [BUS_W-1:0]     data_o,
  output logic [NUM_LANES-1:0] lock_o
);
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  logic act_level, act_rise;

  bert_act_filter #(.HOLD(FILT_LEN)) filt_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .raw_i   (act_i),
    .level_o (act_level),
    .rise_o  (act_rise)
  );

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             mode_q, mode_d;

  always_comb begin
    sel_d  = sel_q;
    mode_d = mode_q;
    if (act_rise) begin
      sel_d  = chan_sel_i;
      mode_d = mode_req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sel_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      mode_q <= mode_d;
    end
  end

  logic [NUM_LANES-1:0] lane_test;

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
    assign lane_test[c] = act_level &&
                          ((sel_q == '0) || (sel_q == SEL_W'(c + 1)));

    bert_lane lane_i (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .test_i    (lane_test[c]),
      .bitmode_i (mode_q),
      .rx_i      (rx_data_i[c*WORD_W +: WORD_W]),
      .lock_i    (rx_lock_i[c]),
      .data_o    (data_o[c*WORD_W +: WORD_W]),
      .lock_o    (lock_o[c])
    );
  end

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n_int)
    (act_level && $past(act_level)) |-> ($stable(sel_q) && $stable(mode_q)));

  a_r3_single_or_all: assert property (@(posedge clk) disable iff (!rst_n_int)
    act_level |-> ($onehot0(lane_test) || (&lane_test)));
endmodule

// File: tb/bert_standalone_ctrl_tb_top.sv
module bert_standalone_ctrl_tb_top;
  import bert_pkg::*;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 act_i;
  logic                 mode_req_i;
  logic [SEL_W-1:0]     chan_sel_i;
  logic [BUS_W-1:0]     rx_data_i;
  logic [NUM_LANES-1:0] rx_lock_i;
  logic [BUS_W-1:0]     data_o;
  logic [NUM_LANES-1:0] lock_o;

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] txw [NUM_LANES];

  localparam logic [NUM_LANES-1:0] LOCKP = 6'b101101;
  localparam logic [BUS_W-1:0]     ZBUS  = '0;

  // {error mask injected on channel 3, expected report} in bit mode
  localparam logic [2*WORD_W-1:0] BIT_VEC [8] = '{
    {10'h000, 10'h000}, {10'h001, 10'h001}, {10'h000, 10'h000},
    {10'h200, 10'h200}, {10'h3FF, 10'h3FF}, {10'h000, 10'h000},
    {10'h155, 10'h155}, {10'h040, 10'h040}
  };

  always #5 clk = ~clk;

  bert_standalone_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (act_i),
    .mode_req_i (mode_req_i),
    .chan_sel_i (chan_sel_i),
    .rx_data_i  (rx_data_i),
    .rx_lock_i  (rx_lock_i),
    .data_o     (data_o),
    .lock_o     (lock_o)
  );

  function automatic logic [WORD_W-1:0] gen_next(input logic [WORD_W-1:0] w);
    return {w[8:0], w[9] ^ w[6]};
  endfunction

  function automatic logic [BUS_W-1:0] put(input logic [BUS_W-1:0] b, input int c,
                                           input logic [WORD_W-1:0] w);
    logic [BUS_W-1:0] r;
    r = b;
    r[c*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  task automatic step(input logic a, input logic m, input logic [SEL_W-1:0] s,
                      input logic [BUS_W-1:0] err);
    @(negedge clk);
    act_i      = a;
    mode_req_i = m;
    chan_sel_i = s;
    for (int c = 0; c < NUM_LANES; c++) begin
      txw[c] = gen_next(txw[c]);
      rx_data_i[c*WORD_W +: WORD_W] = txw[c] ^ err[c*WORD_W +: WORD_W];
    end
    #2;
  endtask

  task automatic check(input string req, input logic [BUS_W-1:0] exp_d,
                       input logic [NUM_LANES-1:0] exp_l);
    checks++;
    if (data_o !== exp_d || lock_o !== exp_l) begin
      errors++;
      $display("FAIL %s: data %h lock %b, expected data %h lock %b",
               req, data_o, lock_o, exp_d, exp_l);
    end
  endtask

  task automatic check_pass(input string req);
    check(req, rx_data_i, rx_lock_i);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    act_i      = 1'b0;
    mode_req_i = 1'b0;
    chan_sel_i = '0;
    rx_lock_i  = LOCKP;
    rx_data_i  = '0;
    for (int c = 0; c < NUM_LANES; c++) txw[c] = WORD_W'(c * 37 + 5);

    // R2: reset and idle behaviour
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 3'd0, ZBUS);
      check_pass("R2 in reset");
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 3'd0, ZBUS);
      check_pass("R2 after reset");
    end

    // R1: a 3-sample pulse must not start a run
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 3'd0, ZBUS);
      check_pass("R1 short pulse");
    end
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1, 3'd0, ZBUS);
      check_pass("R1 short pulse ignored");
    end

    // Bit mode on channel 3 (index 2)
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1, 3'd3, ZBUS);
      check_pass("R1 filter delay on rise");
    end
    for (int i = 0; i < 8; i++) begin
      logic [WORD_W-1:0] msk, ex;
      {msk, ex} = BIT_VEC[i];
      // R9: select and mode change mid-run from entry 2 on
      if (i >= 2) step(1'b1, 1'b0, 3'd5, put(ZBUS, 2, msk));
      else        step(1'b1, 1'b1, 3'd3, put(ZBUS, 2, msk));
      check(i == 0 ? "R8 seed word" : "R6 R7 R9 R4 bit report",
            put(rx_data_i, 2, ex), LOCKP & ~6'b000100);
    end
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 3'd5, ZBUS);
      check("R1 filter delay on fall", put(rx_data_i, 2, 10'h000), LOCKP & ~6'b000100);
    end
    step(1'b0, 1'b0, 3'd0, ZBUS);
    check_pass("R1 deactivated");

    // Gross mode on all channels
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 3'd0, ZBUS);
      check_pass("R1 delay gross run");
    end
    step(1'b1, 1'b0, 3'd0, ZBUS);
    check("R3 R8 all-channel seed", ZBUS, 6'b000000);
    step(1'b1, 1'b0, 3'd0, ZBUS);
    check("R3 R5 clean word", ZBUS, 6'b000000);
    step(1'b1, 1'b0, 3'd0, put(ZBUS, 0, 10'h008));
    check("R5 first error", put(ZBUS, 0, 10'h3FF), 6'b000000);
    step(1'b1, 1'b0, 3'd0, ZBUS);
    check("R5 sticky", put(ZBUS, 0, 10'h3FF), 6'b000000);
    step(1'b1, 1'b0, 3'd0, put(ZBUS, 4, 10'h100));
    check("R5 second channel", put(put(ZBUS, 0, 10'h3FF), 4, 10'h3FF), 6'b000000);
    for (int i = 0; i < 2; i++) begin
      step(1'b1, 1'b0, 3'd0, ZBUS);
      check("R5 sticky both", put(put(ZBUS, 0, 10'h3FF), 4, 10'h3FF), 6'b000000);
    end
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 3'd0, ZBUS);
      check("R5 held to deactivation", put(put(ZBUS, 0, 10'h3FF), 4, 10'h3FF), 6'b000000);
    end
    step(1'b0, 1'b0, 3'd0, ZBUS);
    check_pass("R7 all released");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 3'd0, ZBUS);
    step(1'b1, 1'b0, 3'd0, ZBUS);
    step(1'b1, 1'b0, 3'd0, ZBUS);
    check("R5 cleared on new run", ZBUS, 6'b000000);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 3'd0, ZBUS);
    check_pass("R1 deactivated again");

    // R3: select 7 tests nothing
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 3'd7, put(ZBUS, 1, 10'h011));
      if (i >= 4) check_pass("R3 select none");
    end
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 3'd7, ZBUS);

    // R3: select 6 tests only the last channel
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 3'd6, ZBUS);
    step(1'b1, 1'b1, 3'd6, put(ZBUS, 5, 10'h0F0));
    check("R3 select channel 6", put(rx_data_i, 5, 10'h0F0), LOCKP & ~6'b100000);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 3'd6, ZBUS);
    check_pass("R7 final pass-through");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule